// File: doc/BRIEF.md
# Instruction Decoder and Control Unit

This block takes one 32-bit instruction word of a small load/store RISC instruction set and turns it into the control signals a datapath needs. It sorts the word into one of three fixed layouts: register, immediate or jump. It splits out the register indices, the shift amount, the function code and the jump target. It builds the extended immediate. It then chooses the register-write enable and the destination index, the ALU operation, the memory read and write strobes, and the branch and jump kind. Opcodes it does not know, and unknown function codes under opcode 0, are flagged as illegal.

The decoder sits in the decode stage of a pipeline. An instruction presented with `in_valid` high on one rising edge shows its decoded form on the outputs right after that edge, with `out_valid` high. Register file, ALU, memory and program counter logic are outside the block. The decoder settles the destination index, and it drops any write whose destination is register 0, so the register file never has to guard that register itself.

Top module: `dec_ctrl_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is cleared to zero on that edge.
- R2: Fields are taken from fixed bit positions: `rs`=[25:21], `rt`=[20:16], `rd`=[15:11], `shamt`=[10:6], `funct`=[5:0], `jtarget`=[25:0]. `fmt` is 0 for opcode 0, 2 for opcodes 2 and 3, 1 for the other legal opcodes, and 3 for an illegal word.
- R3: Under opcode 0, funct 32 (add), 34 (sub) and 42 (slt) give `alu_op` 0, 1 and 2. They set `dst_sel`=1 (rd) and `dst_idx`=rd, and they write.
- R4: Opcode 0 with funct 8 (jr) gives `jmp_kind`=3 and `alu_op`=15 (none), with no write and no memory access.
- R5: Opcode 35 (lw) sets `mem_rd` and writes rt (`dst_sel`=2). Opcode 43 (sw) sets `mem_wr` and does not write. Both use `alu_op`=0 (add) and the sign-extended immediate, and the two strobes are never high together.
- R6: Opcode 4 (beq) gives `br_kind`=1 and opcode 5 (bne) gives `br_kind`=2. Both use `alu_op`=1 (sub) and the sign-extended immediate, and neither writes.
- R7: Opcodes 8 (addi) and 10 (slti) sign-extend the immediate and use `alu_op` 0 and 2. Opcodes 12 (andi) and 13 (ori) zero-extend it and use `alu_op` 3 and 4. All four write rt.
- R8: Opcode 15 (lui) gives `imm_ext` = immediate in [31:16] with zeros in [15:0], and `alu_op`=5 (pass upper immediate). It writes rt.
- R9: Opcode 2 (j) gives `jmp_kind`=1 with no write. Opcode 3 (jal) gives `jmp_kind`=2, `dst_sel`=3 and `dst_idx`=31, and it writes. Both use `alu_op`=15.
- R10: A write whose destination index is 0 is suppressed: `reg_we` stays low, and the other controls are unchanged.
- R11: An unlisted opcode, or an unlisted funct under opcode 0, sets `illegal`. It clears `reg_we`, `mem_rd`, `mem_wr`, `br_kind`, `jmp_kind`, `dst_sel`, `dst_idx` and `imm_ext`, and it gives `alu_op`=15.
- R12: `out_valid` follows `in_valid` one edge later. When `in_valid` is low, all other outputs keep their previous values.
- R13: For register-layout and jump-layout words, `imm_ext` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded outputs valid |
| fmt | output | 2 | Layout: 0 register, 1 immediate, 2 jump, 3 illegal |
| rs | output | 5 | First source index |
| rt | output | 5 | Second source index |
| rd | output | 5 | Register-layout destination field |
| shamt | output | 5 | Shift amount field |
| funct | output | 6 | Function code field |
| jtarget | output | 26 | Jump target field |
| imm_ext | output | 32 | Extended immediate |
| reg_we | output | 1 | Register write enable |
| dst_sel | output | 2 | Destination source: 0 none, 1 rd, 2 rt, 3 link |
| dst_idx | output | 5 | Destination register index |
| alu_op | output | 4 | ALU operation code |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| br_kind | output | 2 | Branch: 0 none, 1 equal, 2 not equal |
| jmp_kind | output | 2 | Jump: 0 none, 1 direct, 2 direct with link, 3 register |
| illegal | output | 1 | Illegal instruction |

## Verification
Some properties are checked by assertions on every valid cycle. An illegal word never writes or touches memory. A written destination is never register 0. The two memory strobes are exclusive, and a store never writes a register. Every branch compares by subtraction without a write. A link jump always writes register 31, and jump-layout words carry a zero immediate. The assertions also check that `out_valid` follows `in_valid` and that the outputs hold while it is low. The actual encodings need the bench's scenarios: which opcode and funct map to which ALU code, and the sign versus zero extension of negative immediates. The same goes for the placement of the lui immediate and the exact field bit positions.

// File: rtl/dec_ctrl_pkg.sv
// Package: shared encodings and the control bundle for the instruction decoder.
// Assumes a 32-bit word with a 6-bit opcode and 5-bit register indices.
package dec_ctrl_pkg;

    localparam int OPW  = 6;
    localparam int FNW  = 6;

    localparam logic [OPW-1:0] OP_REG  = 6'd0;
    localparam logic [OPW-1:0] OP_J    = 6'd2;
    localparam logic [OPW-1:0] OP_JAL  = 6'd3;
    localparam logic [OPW-1:0] OP_BEQ  = 6'd4;
    localparam logic [OPW-1:0] OP_BNE  = 6'd5;
    localparam logic [OPW-1:0] OP_ADDI = 6'd8;
    localparam logic [OPW-1:0] OP_SLTI = 6'd10;
    localparam logic [OPW-1:0] OP_ANDI = 6'd12;
    localparam logic [OPW-1:0] OP_ORI  = 6'd13;
    localparam logic [OPW-1:0] OP_LUI  = 6'd15;
    localparam logic [OPW-1:0] OP_LW   = 6'd35;
    localparam logic [OPW-1:0] OP_SW   = 6'd43;

    localparam logic [FNW-1:0] FN_JR   = 6'd8;
    localparam logic [FNW-1:0] FN_ADD  = 6'd32;
    localparam logic [FNW-1:0] FN_SUB  = 6'd34;
    localparam logic [FNW-1:0] FN_SLT  = 6'd42;

    typedef enum logic [1:0] {
        FMT_REG = 2'd0, FMT_IMM = 2'd1, FMT_JMP = 2'd2, FMT_BAD = 2'd3
    } fmt_e;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'd0, ALU_SUB = 4'd1, ALU_SLT = 4'd2, ALU_AND = 4'd3,
        ALU_OR   = 4'd4, ALU_LUI = 4'd5, ALU_NONE = 4'd15
    } alu_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0, DST_RD = 2'd1, DST_RT = 2'd2, DST_LINK = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2
    } br_e;

    typedef enum logic [1:0] {
        JMP_NONE = 2'd0, JMP_DIR = 2'd1, JMP_LINK = 2'd2, JMP_REG = 2'd3
    } jmp_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0, IMM_SEXT = 2'd1, IMM_ZEXT = 2'd2, IMM_UPPER = 2'd3
    } imm_e;

    typedef struct packed {
        fmt_e  fmt;
        logic  wr_req;
        dst_e  dsel;
        alu_e  alu;
        logic  mrd;
        logic  mwr;
        br_e   br;
        jmp_e  jmp;
        imm_e  ik;
        logic  bad;
    } ctl_t;

endpackage

// File: rtl/dec_fields.sv
// Module: splits an instruction word into its fixed-position fields.
// Assumes the opcode in the top bits, then three register indices, then the
// shift amount and function code; the immediate and jump target share low bits.
module dec_fields #(
    parameter int IW = 32,
    parameter int AW = 5,
    parameter int OPW = 6,
    parameter int FNW = 6
) (
    input  logic [IW-1:0]        word,
    output logic [OPW-1:0]       op,
    output logic [AW-1:0]        rs,
    output logic [AW-1:0]        rt,
    output logic [AW-1:0]        rd,
    output logic [AW-1:0]        shamt,
    output logic [FNW-1:0]       funct,
    output logic [IW-3*AW-OPW+AW+FNW-1:0] imm,
    output logic [IW-OPW-1:0]    tgt
);
    localparam int RS_LO = IW - OPW - AW;
    localparam int RT_LO = RS_LO - AW;
    localparam int RD_LO = RT_LO - AW;
    localparam int SH_LO = RD_LO - AW;
    localparam int IMW   = RT_LO;

    // Purpose: slice each field from its fixed position.
    always_comb begin
        op    = word[IW-1 -: OPW];
        rs    = word[RS_LO +: AW];
        rt    = word[RT_LO +: AW];
        rd    = word[RD_LO +: AW];
        shamt = word[SH_LO +: AW];
        funct = word[FNW-1:0];
        imm   = word[IMW-1:0];
        tgt   = word[IW-OPW-1:0];
    end
endmodule

// File: rtl/dec_imm_gen.sv
// Module: widens the 16-bit immediate to the data width in one of four ways.
// Assumes the kind code comes from the control table; NONE yields zero.
module dec_imm_gen
    import dec_ctrl_pkg::*;
#(
    parameter int XW  = 32,
    parameter int IMW = 16
) (
    input  logic [IMW-1:0] imm,
    input  imm_e           kind,
    output logic [XW-1:0]  ext
);
    localparam int PADW = XW - IMW;

    // Purpose: pick sign-fill, zero-fill, upper placement or zero.
    always_comb begin
        unique case (kind)
            IMM_SEXT:  ext = {{PADW{imm[IMW-1]}}, imm};
            IMM_ZEXT:  ext = {{PADW{1'b0}}, imm};
            IMM_UPPER: ext = {imm, {PADW{1'b0}}};
            default:   ext = '0;
        endcase
    end
endmodule

// File: rtl/dec_ctrl_table.sv
// Module: maps opcode and function code to the control bundle.
// Assumes unknown codes must come out inert, with only the illegal bit set.
module dec_ctrl_table
    import dec_ctrl_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [FNW-1:0] funct,
    output ctl_t           ctl
);
    localparam ctl_t IDLE = '{fmt: FMT_BAD, wr_req: 1'b0, dsel: DST_NONE,
                              alu: ALU_NONE, mrd: 1'b0, mwr: 1'b0,
                              br: BR_NONE, jmp: JMP_NONE, ik: IMM_NONE,
                              bad: 1'b1};

    // Purpose: decode one instruction into its controls.
    always_comb begin
        ctl = IDLE;
        unique case (op)
            OP_REG: begin
                ctl.fmt = FMT_REG;
                ctl.bad = 1'b0;
                unique case (funct)
                    FN_ADD: begin ctl.alu = ALU_ADD; ctl.wr_req = 1'b1; ctl.dsel = DST_RD; end
                    FN_SUB: begin ctl.alu = ALU_SUB; ctl.wr_req = 1'b1; ctl.dsel = DST_RD; end
                    FN_SLT: begin ctl.alu = ALU_SLT; ctl.wr_req = 1'b1; ctl.dsel = DST_RD; end
                    FN_JR:  ctl.jmp = JMP_REG;
                    default: begin ctl.fmt = FMT_BAD; ctl.bad = 1'b1; end
                endcase
            end
            OP_LW: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_ADD; ctl.ik = IMM_SEXT;
                ctl.mrd = 1'b1; ctl.wr_req = 1'b1; ctl.dsel = DST_RT;
            end
            OP_SW: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_ADD; ctl.ik = IMM_SEXT;
                ctl.mwr = 1'b1;
            end
            OP_BEQ: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_SUB; ctl.ik = IMM_SEXT;
                ctl.br = BR_EQ;
            end
            OP_BNE: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_SUB; ctl.ik = IMM_SEXT;
                ctl.br = BR_NE;
            end
            OP_ADDI: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_ADD; ctl.ik = IMM_SEXT;
                ctl.wr_req = 1'b1; ctl.dsel = DST_RT;
            end
            OP_SLTI: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_SLT; ctl.ik = IMM_SEXT;
                ctl.wr_req = 1'b1; ctl.dsel = DST_RT;
            end
            OP_ANDI: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_AND; ctl.ik = IMM_ZEXT;
                ctl.wr_req = 1'b1; ctl.dsel = DST_RT;
            end
            OP_ORI: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_OR; ctl.ik = IMM_ZEXT;
                ctl.wr_req = 1'b1; ctl.dsel = DST_RT;
            end
            OP_LUI: begin
                ctl.fmt = FMT_IMM; ctl.bad = 1'b0; ctl.alu = ALU_LUI; ctl.ik = IMM_UPPER;
                ctl.wr_req = 1'b1; ctl.dsel = DST_RT;
            end
            OP_J: begin
                ctl.fmt = FMT_JMP; ctl.bad = 1'b0; ctl.jmp = JMP_DIR;
            end
            OP_JAL: begin
                ctl.fmt = FMT_JMP; ctl.bad = 1'b0; ctl.jmp = JMP_LINK;
                ctl.wr_req = 1'b1; ctl.dsel = DST_LINK;
            end
            default: ctl = IDLE;
        endcase
    end
endmodule

// File: rtl/dec_ctrl_unit.sv
// Module: decode-stage instruction decoder with a registered control output.
// Assumes a new word may arrive on every edge it is flagged valid; outputs
// hold while no word is offered. Writes to register 0 are dropped here.
module dec_ctrl_unit
    import dec_ctrl_pkg::*;
#(
    parameter int XW   = 32,
    parameter int AW   = 5,
    parameter int LINK = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   instr,
    output logic          out_valid,
    output logic [1:0]    fmt,
    output logic [4:0]    rs,
    output logic [4:0]    rt,
    output logic [4:0]    rd,
    output logic [4:0]    shamt,
    output logic [5:0]    funct,
    output logic [25:0]   jtarget,
    output logic [31:0]   imm_ext,
    output logic          reg_we,
    output logic [1:0]    dst_sel,
    output logic [4:0]    dst_idx,
    output logic [3:0]    alu_op,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [1:0]    br_kind,
    output logic [1:0]    jmp_kind,
    output logic          illegal
);
    localparam int IMW = XW - OPW - 2*AW;
    localparam int TGW = XW - OPW;
    localparam logic [AW-1:0] LINK_IDX = AW'(LINK);

    logic [OPW-1:0] f_op;
    logic [AW-1:0]  f_rs, f_rt, f_rd, f_sh;
    logic [FNW-1:0] f_fn;
    logic [IMW-1:0] f_imm;
    logic [TGW-1:0] f_tgt;
    ctl_t           ctl;
    logic [XW-1:0]  ext;
    logic [AW-1:0]  nxt_idx;
    logic           nxt_we;

    dec_fields #(.IW(XW), .AW(AW), .OPW(OPW), .FNW(FNW)) u_fields (
        .word(instr), .op(f_op), .rs(f_rs), .rt(f_rt), .rd(f_rd),
        .shamt(f_sh), .funct(f_fn), .imm(f_imm), .tgt(f_tgt)
    );

    dec_ctrl_table u_table (.op(f_op), .funct(f_fn), .ctl(ctl));

    dec_imm_gen #(.XW(XW), .IMW(IMW)) u_imm (.imm(f_imm), .kind(ctl.ik), .ext(ext));

    // Purpose: resolve the destination index and drop writes to register 0.
    always_comb begin
        unique case (ctl.dsel)
            DST_RD:   nxt_idx = f_rd;
            DST_RT:   nxt_idx = f_rt;
            DST_LINK: nxt_idx = LINK_IDX;
            default:  nxt_idx = '0;
        endcase
        nxt_we = ctl.wr_req && (nxt_idx != '0);
    end

    // Purpose: capture the decoded word on a valid edge, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            fmt       <= '0;
            rs        <= '0;
            rt        <= '0;
            rd        <= '0;
            shamt     <= '0;
            funct     <= '0;
            jtarget   <= '0;
            imm_ext   <= '0;
            reg_we    <= 1'b0;
            dst_sel   <= '0;
            dst_idx   <= '0;
            alu_op    <= '0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            br_kind   <= '0;
            jmp_kind  <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fmt       <= ctl.fmt;
                rs        <= f_rs;
                rt        <= f_rt;
                rd        <= f_rd;
                shamt     <= f_sh;
                funct     <= f_fn;
                jtarget   <= f_tgt;
                imm_ext   <= ext;
                reg_we    <= nxt_we;
                dst_sel   <= ctl.dsel;
                dst_idx   <= nxt_idx;
                alu_op    <= ctl.alu;
                mem_rd    <= ctl.mrd;
                mem_wr    <= ctl.mwr;
                br_kind   <= ctl.br;
                jmp_kind  <= ctl.jmp;
                illegal   <= ctl.bad;
            end
        end
    end

    AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!reg_we && !mem_rd && !mem_wr && br_kind == 2'd0 && jmp_kind == 2'd0)); // R11
    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (dst_idx != 5'd0)); // R10
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}) && (mem_wr -> !reg_we)); // R5
    AST_BRANCH_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind != 2'd0) |-> (!reg_we && alu_op == 4'd1)); // R6
    AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_kind == 2'd2) |-> (reg_we && dst_idx == 5'd31)); // R9
    AST_JFMT_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd2) |-> (imm_ext == 32'd0)); // R13
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R12
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(alu_op) && $stable(imm_ext) && $stable(dst_idx))); // R12
endmodule

// File: tb/sim_dec_ctrl_unit.sv
`timescale 1ns/1ps
module sim_dec_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        out_valid, reg_we, mem_rd, mem_wr, illegal;
    logic [1:0]  fmt, dst_sel, br_kind, jmp_kind;
    logic [4:0]  rs, rt, rd, shamt, dst_idx;
    logic [5:0]  funct;
    logic [25:0] jtarget;
    logic [31:0] imm_ext;
    logic [3:0]  alu_op;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dec_ctrl_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .out_valid(out_valid), .fmt(fmt), .rs(rs), .rt(rt), .rd(rd),
        .shamt(shamt), .funct(funct), .jtarget(jtarget), .imm_ext(imm_ext),
        .reg_we(reg_we), .dst_sel(dst_sel), .dst_idx(dst_idx), .alu_op(alu_op),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .br_kind(br_kind),
        .jmp_kind(jmp_kind), .illegal(illegal)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] s, t, d, sh, input logic [5:0] fn);
        return {6'd0, s, t, d, sh, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s, t, input logic [15:0] im);
        return {op, s, t, im};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tg);
        return {op, tg};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one word at the falling edge, sample one ns after the next rise.
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    // Compare the whole control bundle.
    task automatic chk_ctl(input string tag, input logic [1:0] e_fmt, input logic e_we,
                           input logic [1:0] e_sel, input logic [4:0] e_idx, input logic [3:0] e_alu,
                           input logic e_rd, input logic e_wr, input logic [1:0] e_br,
                           input logic [1:0] e_jmp, input logic [31:0] e_imm, input logic e_bad);
        chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
        chk({tag, " fmt"}, 32'(fmt), 32'(e_fmt));
        chk({tag, " reg_we"}, 32'(reg_we), 32'(e_we));
        chk({tag, " dst_sel"}, 32'(dst_sel), 32'(e_sel));
        chk({tag, " dst_idx"}, 32'(dst_idx), 32'(e_idx));
        chk({tag, " alu_op"}, 32'(alu_op), 32'(e_alu));
        chk({tag, " mem_rd"}, 32'(mem_rd), 32'(e_rd));
        chk({tag, " mem_wr"}, 32'(mem_wr), 32'(e_wr));
        chk({tag, " br_kind"}, 32'(br_kind), 32'(e_br));
        chk({tag, " jmp_kind"}, 32'(jmp_kind), 32'(e_jmp));
        chk({tag, " imm_ext"}, imm_ext, e_imm);
        chk({tag, " illegal"}, 32'(illegal), 32'(e_bad));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 reg_we", 32'(reg_we), 32'd0);
        chk("R1 imm_ext", imm_ext, 32'd0);
        chk("R1 alu_op", 32'(alu_op), 32'd0);
        chk("R1 illegal", 32'(illegal), 32'd0);
    endtask

    task automatic t_fields();
        issue(enc_r(5'd17, 5'd18, 5'd9, 5'd21, 6'd32));
        chk("R2 rs", 32'(rs), 32'd17);
        chk("R2 rt", 32'(rt), 32'd18);
        chk("R2 rd", 32'(rd), 32'd9);
        chk("R2 shamt", 32'(shamt), 32'd21);
        chk("R2 funct", 32'(funct), 32'd32);
        issue(enc_j(6'd2, 26'h2ABCDEF));
        chk("R2 jtarget", 32'(jtarget), 32'h2ABCDEF);
        chk("R2 fmt jump", 32'(fmt), 32'd2);
    endtask

    task automatic t_rtype();
        issue(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'd32));
        chk_ctl("R3 add", 2'd0, 1, 2'd1, 5'd3, 4'd0, 0, 0, 2'd0, 2'd0, 32'd0, 0);
        issue(enc_r(5'd4, 5'd5, 5'd6, 5'd0, 6'd34));
        chk_ctl("R3 sub", 2'd0, 1, 2'd1, 5'd6, 4'd1, 0, 0, 2'd0, 2'd0, 32'd0, 0);
        issue(enc_r(5'd7, 5'd8, 5'd31, 5'd0, 6'd42));
        chk_ctl("R3 slt R13", 2'd0, 1, 2'd1, 5'd31, 4'd2, 0, 0, 2'd0, 2'd0, 32'd0, 0);
        issue(enc_r(5'd31, 5'd0, 5'd0, 5'd0, 6'd8));
        chk_ctl("R4 jr", 2'd0, 0, 2'd0, 5'd0, 4'd15, 0, 0, 2'd0, 2'd3, 32'd0, 0);
    endtask

    task automatic t_mem();
        issue(enc_i(6'd35, 5'd18, 5'd9, 16'h0020));
        chk_ctl("R5 lw", 2'd1, 1, 2'd2, 5'd9, 4'd0, 1, 0, 2'd0, 2'd0, 32'h20, 0);
        issue(enc_i(6'd43, 5'd19, 5'd8, 16'hFFF0));
        chk_ctl("R5 sw", 2'd1, 0, 2'd0, 5'd0, 4'd0, 0, 1, 2'd0, 2'd0, 32'hFFFFFFF0, 0);
    endtask

    task automatic t_branch();
        issue(enc_i(6'd4, 5'd8, 5'd9, 16'h8000));
        chk_ctl("R6 beq", 2'd1, 0, 2'd0, 5'd0, 4'd1, 0, 0, 2'd1, 2'd0, 32'hFFFF8000, 0);
        issue(enc_i(6'd5, 5'd8, 5'd9, 16'h0004));
        chk_ctl("R6 bne", 2'd1, 0, 2'd0, 5'd0, 4'd1, 0, 0, 2'd2, 2'd0, 32'h4, 0);
    endtask

    task automatic t_immarith();
        issue(enc_i(6'd8, 5'd29, 5'd29, 16'hFFFC));
        chk_ctl("R7 addi", 2'd1, 1, 2'd2, 5'd29, 4'd0, 0, 0, 2'd0, 2'd0, 32'hFFFFFFFC, 0);
        issue(enc_i(6'd10, 5'd18, 5'd8, 16'h800A));
        chk_ctl("R7 slti", 2'd1, 1, 2'd2, 5'd8, 4'd2, 0, 0, 2'd0, 2'd0, 32'hFFFF800A, 0);
        issue(enc_i(6'd12, 5'd29, 5'd29, 16'hF006));
        chk_ctl("R7 andi", 2'd1, 1, 2'd2, 5'd29, 4'd3, 0, 0, 2'd0, 2'd0, 32'h0000F006, 0);
        issue(enc_i(6'd13, 5'd8, 5'd8, 16'hAAAA));
        chk_ctl("R7 ori", 2'd1, 1, 2'd2, 5'd8, 4'd4, 0, 0, 2'd0, 2'd0, 32'h0000AAAA, 0);
    endtask

    task automatic t_lui();
        issue(enc_i(6'd15, 5'd0, 5'd8, 16'hAAAA));
        chk_ctl("R8 lui", 2'd1, 1, 2'd2, 5'd8, 4'd5, 0, 0, 2'd0, 2'd0, 32'hAAAA0000, 0);
        issue(enc_i(6'd15, 5'd0, 5'd8, 16'h8001));
        chk("R8 lui high bit", imm_ext, 32'h80010000);
    endtask

    task automatic t_jump();
        issue(enc_j(6'd2, 26'h3FFFFFF));
        chk_ctl("R9 j R13", 2'd2, 0, 2'd0, 5'd0, 4'd15, 0, 0, 2'd0, 2'd1, 32'd0, 0);
        issue(enc_j(6'd3, 26'h0001234));
        chk_ctl("R9 jal", 2'd2, 1, 2'd3, 5'd31, 4'd15, 0, 0, 2'd0, 2'd2, 32'd0, 0);
    endtask

    task automatic t_zero_dest();
        issue(enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'd32));
        chk_ctl("R10 add to r0", 2'd0, 0, 2'd1, 5'd0, 4'd0, 0, 0, 2'd0, 2'd0, 32'd0, 0);
        issue(enc_i(6'd35, 5'd3, 5'd0, 16'h0008));
        chk_ctl("R10 lw to r0", 2'd1, 0, 2'd2, 5'd0, 4'd0, 1, 0, 2'd0, 2'd0, 32'h8, 0);
        issue(enc_i(6'd15, 5'd0, 5'd0, 16'h1234));
        chk_ctl("R10 lui to r0", 2'd1, 0, 2'd2, 5'd0, 4'd5, 0, 0, 2'd0, 2'd0, 32'h12340000, 0);
    endtask

    task automatic t_illegal();
        issue(enc_i(6'd63, 5'd1, 5'd2, 16'hFFFF));
        chk_ctl("R11 bad op", 2'd3, 0, 2'd0, 5'd0, 4'd15, 0, 0, 2'd0, 2'd0, 32'd0, 1);
        issue(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'd33));
        chk_ctl("R11 bad funct", 2'd3, 0, 2'd0, 5'd0, 4'd15, 0, 0, 2'd0, 2'd0, 32'd0, 1);
        issue(enc_i(6'd1, 5'd1, 5'd5, 16'h0001));
        chk_ctl("R11 op1", 2'd3, 0, 2'd0, 5'd0, 4'd15, 0, 0, 2'd0, 2'd0, 32'd0, 1);
        issue(enc_i(6'd35, 5'd1, 5'd5, 16'h0001));
        chk("R11 recovers illegal", 32'(illegal), 32'd0);
    endtask

    task automatic t_hold();
        issue(enc_i(6'd13, 5'd4, 5'd7, 16'h00F0));
        @(negedge clk);
        in_valid = 1'b0;
        instr = enc_i(6'd43, 5'd1, 5'd2, 16'hFFFF);
        @(posedge clk);
        #1;
        chk("R12 out_valid low", 32'(out_valid), 32'd0);
        chk("R12 alu held", 32'(alu_op), 32'd4);
        chk("R12 imm held", imm_ext, 32'h000000F0);
        chk("R12 mem_wr held", 32'(mem_wr), 32'd0);
        chk("R12 dst held", 32'(dst_idx), 32'd7);
        @(posedge clk);
        #1;
        chk("R12 still held", 32'(reg_we), 32'd1);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 50000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_fields();
        t_rtype();
        t_mem();
        t_branch();
        t_immarith();
        t_lui();
        t_jump();
        t_zero_dest();
        t_illegal();
        t_hold();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset clears valid", 32'(out_valid), 32'd0);
        chk("R1 reset clears we", 32'(reg_we), 32'd0);
        finish_run();
    end
endmodule